// File: doc/BRIEF.md
# Backward Error Count Accumulator

This block adds up the per-frame backward error count that the far end reports in the section monitoring overhead. A frame strobe goes with each 4-bit field value. Values from 1 to 8 go into a saturating accumulator. All other values are discarded. Once per second a tick copies the accumulator into a snapshot register, where software reads it. A mode bit chooses what happens to the accumulator after the copy: it restarts from zero, or it carries on from its current value.

Counting stops while the far end signals a backward defect or an alignment error, and while the local framer has lost signal or frame. An out-of-frame condition also stops counting, but only when its gating control bit is set. Each frame that reports errors sets a sticky status bit, which is cleared by writing 1. The status bit ANDed with its mask bit drives an interrupt output.

Top module: `bei_accum`

## Requirements
- R1: On a cycle with `frameStb` high and no pause condition, a field value `beiVal` from 1 to 8 is added to the accumulator. The accumulator is `AccW` bits wide, 24 by default.
- R2: Field values 0 and 9 to 15 add nothing to the accumulator.
- R3: When `secTick` is high, `snapCount` takes the accumulator value from before that cycle's addition and shows it one cycle later. When `secTick` is low, `snapCount` holds its value.
- R4: After a tick, the accumulator restarts from 0 when `clrOnSnap`=1 and keeps its value when `clrOnSnap`=0.
- R5: While `bdiLive` or `biaeLive` is high, frames add nothing.
- R6: While `lof` or `los` is high, frames add nothing. While `oof` is high, frames add nothing if `oofGateEn`=1; with `oofGateEn`=0, `oof` has no effect.
- R7: The accumulator saturates at all ones and never wraps.
- R8: A frame whose strobe falls in the same cycle as `secTick` is counted in the new period. It is added after the restart and is not included in the snapshot.
- R9: A frame with `beiVal` from 1 to 8 sets `errStatus` one cycle later, even while counting is paused. The bit stays set until it is cleared.
- R10: `statClr`=1 clears `errStatus` on the next cycle. If a new event arrives in the same cycle as the clear, the bit stays set.
- R11: `irq` equals `errStatus` AND `intMask`, with no added delay.
- R12: Reset sets the accumulator, `snapCount` and `errStatus` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStb | input | 1 | One-cycle strobe that marks a new field value |
| beiVal | input | 4 | Backward error field value for the frame |
| bdiLive | input | 1 | Backward defect live bit |
| biaeLive | input | 1 | Backward alignment error live bit |
| lof | input | 1 | Loss of frame |
| los | input | 1 | Loss of signal |
| oof | input | 1 | Out of frame |
| oofGateEn | input | 1 | When 1, `oof` pauses counting |
| secTick | input | 1 | One-second snapshot tick |
| clrOnSnap | input | 1 | 1 restarts the accumulator after a snapshot; 0 keeps its value |
| statClr | input | 1 | Write-1 clear for `errStatus` |
| intMask | input | 1 | Interrupt enable for `errStatus` |
| snapCount | output | AccW (24) | Snapshot register for software reads |
| errStatus | output | 1 | Sticky error-frame status |
| irq | output | 1 | Masked interrupt |

## Verification
The accumulator, the snapshot and the status bit are each one register stage from their inputs, so their results appear one edge after the stimulus. `irq` is combinational from the status bit and the mask. The bench drives each vector on a falling edge and lets exactly one rising edge pass. It then compares on the next falling edge against a model that it updates from the same vector. The accumulator is internal and is seen only through the snapshot, so every accumulation result is checked by a later tick. Saturation is checked with a narrower accumulator, so that the limit is reached in a few frames.

// File: rtl/bei_accum_pkg.sv
package bei_accum_pkg;
  typedef struct packed {
    logic addEn;    // add this frame's value
    logic restart;  // drop the old count at the snapshot
    logic snap;     // copy the count into the snapshot register
  } accStrobes_t;
endpackage

// File: rtl/bei_accum_ctl.sv
module bei_accum_ctl
  import bei_accum_pkg::*;
#(
  parameter int ValW   = 4,
  parameter int MinCnt = 1,
  parameter int MaxCnt = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStb,
  input  logic [ValW-1:0] beiVal,
  input  logic            bdiLive,
  input  logic            biaeLive,
  input  logic            lof,
  input  logic            los,
  input  logic            oof,
  input  logic            oofGateEn,
  input  logic            secTick,
  input  logic            clrOnSnap,
  input  logic            statClr,
  input  logic            intMask,
  output accStrobes_t     stb,
  output logic            errStatus,
  output logic            irq
);
  logic inRange;
  logic paused;
  logic errEvent;

  assign inRange  = (beiVal >= ValW'(MinCnt)) && (beiVal <= ValW'(MaxCnt));
  assign paused   = bdiLive | biaeLive | lof | los | (oof & oofGateEn);
  assign errEvent = frameStb & inRange;

  always_comb begin
    stb.addEn   = errEvent & ~paused;
    stb.snap    = secTick;
    stb.restart = secTick & clrOnSnap;
  end

  // sticky status: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         errStatus <= 1'b0;
    else if (errEvent) errStatus <= 1'b1;
    else if (statClr)  errStatus <= 1'b0;
  end

  assign irq = errStatus & intMask;
endmodule

// File: rtl/bei_accum_dp.sv
module bei_accum_dp
  import bei_accum_pkg::*;
#(
  parameter int AccW = 24,
  parameter int ValW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  accStrobes_t     stb,
  input  logic [ValW-1:0] addVal,
  output logic [AccW-1:0] accCur,
  output logic [AccW-1:0] snapCount
);
  localparam int SumW = AccW + 1;

  logic [AccW-1:0] base;
  logic [SumW-1:0] sum;
  logic [AccW-1:0] satSum;
  logic [AccW-1:0] accNext;

  always_comb begin
    base    = stb.restart ? '0 : accCur;
    sum     = {1'b0, base} + {{(SumW-ValW){1'b0}}, addVal};
    satSum  = sum[AccW] ? '1 : sum[AccW-1:0];
    accNext = stb.addEn ? satSum : base;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accCur    <= '0;
      snapCount <= '0;
    end else begin
      accCur <= accNext;
      if (stb.snap) snapCount <= accCur;
    end
  end
endmodule

// File: rtl/bei_accum.sv
module bei_accum
  import bei_accum_pkg::*;
#(
  parameter int AccW = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStb,
  input  logic [3:0]      beiVal,
  input  logic            bdiLive,
  input  logic            biaeLive,
  input  logic            lof,
  input  logic            los,
  input  logic            oof,
  input  logic            oofGateEn,
  input  logic            secTick,
  input  logic            clrOnSnap,
  input  logic            statClr,
  input  logic            intMask,
  output logic [AccW-1:0] snapCount,
  output logic            errStatus,
  output logic            irq
);
  localparam int ValW = 4;

  accStrobes_t     stb;
  logic [AccW-1:0] accCur;

  bei_accum_ctl #(.ValW(ValW)) u_ctl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .beiVal(beiVal),
    .bdiLive(bdiLive), .biaeLive(biaeLive), .lof(lof), .los(los),
    .oof(oof), .oofGateEn(oofGateEn), .secTick(secTick),
    .clrOnSnap(clrOnSnap), .statClr(statClr), .intMask(intMask),
    .stb(stb), .errStatus(errStatus), .irq(irq)
  );

  bei_accum_dp #(.AccW(AccW), .ValW(ValW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addVal(beiVal),
    .accCur(accCur), .snapCount(snapCount)
  );
endmodule

// File: rtl/bei_accum_chk.sv
module bei_accum_chk #(
  parameter int AccW = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameStb,
  input logic [3:0]      beiVal,
  input logic            bdiLive,
  input logic            biaeLive,
  input logic            lof,
  input logic            los,
  input logic            oof,
  input logic            oofGateEn,
  input logic            secTick,
  input logic            statClr,
  input logic            intMask,
  input logic [AccW-1:0] accCur,
  input logic [AccW-1:0] snapCount,
  input logic            errStatus,
  input logic            irq
);
  logic anyPause;
  logic goodVal;
  assign anyPause = bdiLive | biaeLive | lof | los | (oof & oofGateEn);
  assign goodVal  = (beiVal >= 4'd1) && (beiVal <= 4'd8);

  // R3
  snap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> snapCount == $past(accCur));
  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> $stable(snapCount));
  // R5 R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (anyPause && !secTick) |=> $stable(accCur));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> accCur >= $past(accCur));
  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && goodVal) |=> errStatus);
  // R10
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statClr && !(frameStb && goodVal)) |=> !errStatus);
  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intMask |-> !irq);
endmodule

bind bei_accum bei_accum_chk #(.AccW(AccW)) u_chk (
  .clk(clk), .rstN(rstN), .frameStb(frameStb), .beiVal(beiVal),
  .bdiLive(bdiLive), .biaeLive(biaeLive), .lof(lof), .los(los),
  .oof(oof), .oofGateEn(oofGateEn), .secTick(secTick),
  .statClr(statClr), .intMask(intMask), .accCur(accCur),
  .snapCount(snapCount), .errStatus(errStatus), .irq(irq)
);

// File: tb/bei_accum_test.sv
module bei_accum_test;
  localparam int AccW = 6;  // narrow so that saturation is reached quickly
  localparam int NVec = 20;
  localparam logic [AccW-1:0] AccMax = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 0, bdiLive = 0, biaeLive = 0, lof = 0, los = 0, oof = 0;
  logic oofGateEn = 0, secTick = 0, clrOnSnap = 0, statClr = 0, intMask = 0;
  logic [3:0] beiVal = '0;
  logic [AccW-1:0] snapCount;
  logic errStatus, irq;

  int applied = 0;
  int fails = 0;
  int mAcc = 0;
  int mSnap = 0;
  logic mStat = 1'b0;

  always #10 clk = ~clk;

  bei_accum #(.AccW(AccW)) uut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .beiVal(beiVal),
    .bdiLive(bdiLive), .biaeLive(biaeLive), .lof(lof), .los(los), .oof(oof),
    .oofGateEn(oofGateEn), .secTick(secTick), .clrOnSnap(clrOnSnap),
    .statClr(statClr), .intMask(intMask), .snapCount(snapCount),
    .errStatus(errStatus), .irq(irq)
  );

  // vector fields: {frame, bei[3:0], pauseSel[2:0], tick, clrMode}
  // pauseSel: 0 none, 1 bdi, 2 biae, 3 lof, 4 los, 5 oof gated, 6 oof ungated
  localparam logic [9:0] VECS [0:NVec-1] = '{
    {1'b1, 4'd3,  3'd0, 1'b0, 1'b0},  // R1
    {1'b1, 4'd8,  3'd0, 1'b0, 1'b0},  // R1
    {1'b1, 4'd9,  3'd0, 1'b0, 1'b0},  // R2
    {1'b1, 4'd0,  3'd0, 1'b0, 1'b0},  // R2
    {1'b1, 4'd5,  3'd1, 1'b0, 1'b0},  // R5
    {1'b1, 4'd5,  3'd2, 1'b0, 1'b0},  // R5
    {1'b1, 4'd5,  3'd3, 1'b0, 1'b0},  // R6
    {1'b1, 4'd5,  3'd4, 1'b0, 1'b0},  // R6
    {1'b1, 4'd5,  3'd5, 1'b0, 1'b0},  // R6
    {1'b1, 4'd5,  3'd6, 1'b0, 1'b0},  // R6
    {1'b0, 4'd0,  3'd0, 1'b1, 1'b0},  // R3 R4
    {1'b1, 4'd1,  3'd0, 1'b0, 1'b0},  // R1
    {1'b1, 4'd2,  3'd0, 1'b1, 1'b1},  // R8
    {1'b1, 4'd15, 3'd0, 1'b0, 1'b0},  // R2
    {1'b1, 4'd7,  3'd0, 1'b0, 1'b0},  // R1
    {1'b0, 4'd0,  3'd0, 1'b1, 1'b1},  // R4
    {1'b1, 4'd4,  3'd0, 1'b0, 1'b0},  // R1
    {1'b0, 4'd0,  3'd0, 1'b1, 1'b0},  // R4
    {1'b1, 4'd8,  3'd0, 1'b0, 1'b0},  // R1
    {1'b0, 4'd0,  3'd0, 1'b1, 1'b1}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // model driven only by the requirements
  task automatic model(input logic fr, input logic [3:0] bv, input logic pz,
                       input logic tk, input logic cm);
    int base;
    logic good;
    good = (bv >= 4'd1) && (bv <= 4'd8);
    base = mAcc;
    if (tk) begin
      mSnap = mAcc;
      if (cm) base = 0;
    end
    if (fr && good && !pz) begin
      base = base + int'(bv);
      if (base > int'(AccMax)) base = int'(AccMax);
    end
    mAcc = base;
    if (fr && good) mStat = 1'b1;
  endtask

  task automatic idle();
    frameStb = 0; beiVal = '0; bdiLive = 0; biaeLive = 0; lof = 0; los = 0;
    oof = 0; oofGateEn = 0; secTick = 0; statClr = 0;
  endtask

  task automatic step(input logic fr, input logic [3:0] bv, input logic [2:0] ps,
                      input logic tk, input logic cm);
    frameStb = fr; beiVal = bv; secTick = tk; clrOnSnap = cm;
    bdiLive = (ps == 3'd1); biaeLive = (ps == 3'd2); lof = (ps == 3'd3);
    los = (ps == 3'd4); oof = (ps == 3'd5) || (ps == 3'd6);
    oofGateEn = (ps == 3'd5);
    model(fr, bv, (ps >= 3'd1) && (ps <= 3'd5), tk, cm);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 snap", int'(snapCount), 0);
    check("R12 status", int'(errStatus), 0);
    rstN = 1'b1;
    @(negedge clk);
    intMask = 1'b1;

    for (int i = 0; i < NVec; i++) begin
      step(VECS[i][9], VECS[i][8:5], VECS[i][4:2], VECS[i][1], VECS[i][0]);
      check("R3 snap", int'(snapCount), mSnap);
      check("R9 status", int'(errStatus), int'(mStat));
      check("R11 irq", int'(irq), int'(mStat));
    end

    // R11 masking
    intMask = 1'b0;
    #1 check("R11 masked", int'(irq), 0);
    // R10 clear
    statClr = 1'b1;
    @(posedge clk); @(negedge clk); statClr = 1'b0;
    mStat = 1'b0;
    check("R10 cleared", int'(errStatus), 0);
    // R10 set wins over clear (R9 event while paused still sets)
    statClr = 1'b1;
    step(1'b1, 4'd2, 3'd1, 1'b0, 1'b0);
    check("R10 set wins", int'(errStatus), 1);
    // R2 value 9 does not set status
    statClr = 1'b1;
    @(posedge clk); @(negedge clk); statClr = 1'b0;
    mStat = 1'b0;
    step(1'b1, 4'd9, 3'd0, 1'b0, 1'b0);
    check("R2 no status", int'(errStatus), 0);

    // R7 saturation in keep mode
    for (int k = 0; k < 10; k++) step(1'b1, 4'd8, 3'd0, 1'b0, 1'b0);
    step(1'b0, 4'd0, 3'd0, 1'b1, 1'b0);
    check("R7 saturate", int'(snapCount), int'(AccMax));
    step(1'b1, 4'd1, 3'd0, 1'b0, 1'b0);
    step(1'b0, 4'd0, 3'd0, 1'b1, 1'b1);
    check("R7 no wrap", int'(snapCount), int'(AccMax));
    // R8 frame with tick counted after restart
    step(1'b1, 4'd6, 3'd0, 1'b1, 1'b1);
    check("R8 snap excludes", int'(snapCount), 0);
    step(1'b0, 4'd0, 3'd0, 1'b1, 1'b1);
    check("R8 new period", int'(snapCount), 6);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule